// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block runs one memory or I/O transfer at a time on an external bus whose lower address bits and data bits share the same pins. A local client presents an address, write data, a direction bit, a memory-or-I/O bit and an access width, and raises a request. The controller then steps through a fixed sequence of bus phases. The first phase puts the address on the shared pins with an address strobe. The middle phases assert the read or write strobe and the buffer enable. The last phase returns everything to the inactive level. A done pulse and the read data come back to the client.

Slow targets stretch the transfer by holding the ready input low. The controller samples ready at the end of the second phase and at the end of every inserted wait phase. It adds one wait phase for each low sample. The address strobe also loads a transparent latch inside the block, which keeps the full demultiplexed address visible for the rest of the transfer. For data paths wider than one byte, an active-low upper-byte enable tells the target whether the upper byte lane takes part.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: While reset is asserted, and until the first request, the block is idle: `ale`=0, `rd_n`=`wr_n`=`den_n`=1, `ad_oe`=0, `dt_r`=0, `io_sel`=0, `bhe_n`=1, `busy`=0, `done`=0, `rdata`=0, `lat_addr`=0.
- R2: A request seen on a clock edge while idle starts a transfer in the next cycle. With `ready` high, `busy` stays high for exactly four cycles (phases T1, T2, T3, T4).
- R3: In T1, `ale`=1 and `ad_oe`=1. `ad_out` carries address bits [DATA_W-1:0], and `a_hi` carries the remaining upper address bits. `dt_r` equals the write bit and `io_sel` equals the I/O bit. No strobe and no buffer enable is active. `a_hi`, `dt_r` and `io_sel` hold these values from T1 through T4.
- R4: `ale` is high in T1 only. From T1 on, `lat_addr` shows the full request address until the next transfer's T1.
- R5: In T2, in every wait phase and in T3, `den_n`=0. A read drives `rd_n`=0 and releases the shared pins (`ad_oe`=0). A write drives `wr_n`=0 with `ad_oe`=1 and the write data on `ad_out`.
- R6: `ready` is sampled at the end of T2 and at the end of each wait phase. A low sample inserts one more wait phase, so a transfer with N low samples lasts 4+N cycles.
- R7: For a read, the shared pins are captured at the end of T3. The value appears on `rdata` during T4 and is held afterwards. A write never changes `rdata`.
- R8: In T4, `rd_n`, `wr_n` and `den_n` are high and `ad_oe` is low. `done` is high in T4 only.
- R9: From T1 through T4, `bhe_n` is 0 when the upper byte lane is used, that is for a word access or for any access to an odd address. It is 1 for a byte access to an even address. It is 1 while idle.
- R10: A request raised while a transfer is in progress is ignored. The current transfer keeps its address and timing, and the block is idle in the cycle after T4.
- R11: `rd_n` and `wr_n` are never low together, and `done` never lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Start a transfer (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_word | input | 1 | 1 = full-width access, 0 = single byte |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse (T4) |
| rdata | output | DATA_W | Last data read |
| ad_out | output | DATA_W | Value driven on the shared address/data pins |
| ad_oe | output | 1 | Output enable of the shared pins |
| ad_in | input | DATA_W | Value seen on the shared pins |
| a_hi | output | ADDR_W-DATA_W | Upper address bits |
| ale | output | 1 | Address strobe, loads the external address latch |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| den_n | output | 1 | Active-low data buffer enable |
| dt_r | output | 1 | Buffer direction: 1 transmit, 0 receive |
| io_sel | output | 1 | 1 = I/O access, 0 = memory access |
| bhe_n | output | 1 | Active-low upper byte lane enable |
| ready | input | 1 | Target ready; low inserts wait phases |
| lat_addr | output | ADDR_W | Address held by the transparent address latch |

## Verification
The assertions assume that `ready` is a clean synchronous level that settles before every sampling edge, and that the target eventually raises it. No timeout is modelled, so a ready held low forever would keep the block in wait phases. They also assume that `ad_in` reflects the pins only while the block has released them. The stimulus changes `ready`, `ad_in` and the request on falling edges only. It keeps `ready` low for a bounded count of 0 to 4 samples per transfer. It moves `ad_in` every cycle, so that a capture on the wrong edge shows up as a wrong value.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T3   = 3'd4,
    PH_T4   = 3'd5
  } mbc_phase_e;

endpackage

// File: rtl/mbc_rst_sync.sv
module mbc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mbc_seq.sv
module mbc_seq
  import mbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       ready,
  output logic       accept,
  output mbc_phase_e phase
);

  mbc_phase_e phase_q;
  mbc_phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: if (req_valid) phase_d = PH_T1;
      PH_T1:   phase_d = PH_T2;
      PH_T2,
      PH_TW:   phase_d = ready ? PH_T3 : PH_TW;
      PH_T3:   phase_d = PH_T4;
      PH_T4:   phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign accept = (phase_q == PH_IDLE) && req_valid;
  assign phase  = phase_q;

endmodule

// File: rtl/mbc_req_reg.sv
module mbc_req_reg #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              cap_rd,
  input  logic              req_write,
  input  logic              req_io,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic              wr_q,
  output logic              io_q,
  output logic              word_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      io_q    <= 1'b0;
      word_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      io_q    <= req_io;
      word_q  <= req_word;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap_rd) begin
      rdata_q <= ad_in;
    end
  end

endmodule

// File: rtl/mbc_pin_drv.sv
module mbc_pin_drv
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  mbc_phase_e               phase,
  input  logic                     wr_q,
  input  logic                     io_q,
  input  logic                     word_q,
  input  logic [ADDR_W-1:0]        addr_q,
  input  logic [DATA_W-1:0]        wdata_q,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     den_n,
  output logic                     dt_r,
  output logic                     io_sel,
  output logic                     bhe_n,
  output logic                     busy,
  output logic                     done
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic in_t1;
  logic in_data;
  logic drv_wd;

  assign in_t1   = (phase == PH_T1);
  assign in_data = (phase == PH_T2) || (phase == PH_TW) || (phase == PH_T3);
  assign busy    = (phase != PH_IDLE);
  assign done    = (phase == PH_T4);
  assign drv_wd  = in_data && wr_q;

  always_comb begin
    ad_out = '0;
    if (in_t1) begin
      ad_out = addr_q[DATA_W-1:0];
    end else if (drv_wd) begin
      ad_out = wdata_q;
    end
  end

  assign ad_oe  = in_t1 || drv_wd;
  assign a_hi   = busy ? addr_q[ADDR_W-1:DATA_W] : {HI_W{1'b0}};
  assign ale    = in_t1;
  assign rd_n   = !(in_data && !wr_q);
  assign wr_n   = !drv_wd;
  assign den_n  = !in_data;
  assign dt_r   = busy && wr_q;
  assign io_sel = busy && io_q;

  generate
    if (DATA_W > 8) begin : g_hi_lane
      assign bhe_n = !(busy && (word_q || addr_q[0]));
    end else begin : g_byte_bus
      logic unused_word;
      assign unused_word = word_q;
      assign bhe_n = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/mbc_addr_latch.sv
module mbc_addr_latch #(
  parameter int ADDR_W = 20
) (
  input  logic              rst_n,
  input  logic              le,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);

  always_latch begin
    if (!rst_n) begin
      q = '0;
    end else if (le) begin
      q = d;
    end
  end

endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
  import mbc_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int RST_STAGE = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic                     req_io,
  input  logic                     req_word,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     busy,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     den_n,
  output logic                     dt_r,
  output logic                     io_sel,
  output logic                     bhe_n,
  input  logic                     ready,
  output logic [ADDR_W-1:0]        lat_addr
);

  logic              rst_i_n;
  logic              accept;
  logic              cap_rd;
  mbc_phase_e        phase;
  logic              wr_q;
  logic              io_q;
  logic              word_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  mbc_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  mbc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .req_valid (req_valid),
    .ready     (ready),
    .accept    (accept),
    .phase     (phase)
  );

  assign cap_rd = (phase == PH_T3) && !wr_q;

  mbc_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .accept    (accept),
    .cap_rd    (cap_rd),
    .req_write (req_write),
    .req_io    (req_io),
    .req_word  (req_word),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ad_in     (ad_in),
    .wr_q      (wr_q),
    .io_q      (io_q),
    .word_q    (word_q),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .rdata_q   (rdata)
  );

  mbc_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .phase   (phase),
    .wr_q    (wr_q),
    .io_q    (io_q),
    .word_q  (word_q),
    .addr_q  (addr_q),
    .wdata_q (wdata_q),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .a_hi    (a_hi),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .den_n   (den_n),
    .dt_r    (dt_r),
    .io_sel  (io_sel),
    .bhe_n   (bhe_n),
    .busy    (busy),
    .done    (done)
  );

  mbc_addr_latch #(.ADDR_W(ADDR_W)) u_lat (
    .rst_n (rst_i_n),
    .le    (ale),
    .d     ({a_hi, ad_out}),
    .q     (lat_addr)
  );

endmodule

// File: rtl/mbc_chk.sv
module mbc_chk
  import mbc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input mbc_phase_e phase,
  input logic       ready,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n,
  input logic       den_n,
  input logic       ad_oe,
  input logic       dt_r,
  input logic       io_sel,
  input logic       busy,
  input logic       done
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R4
  AST_ALE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n && den_n && ad_oe)); // R3
  AST_ALE_THEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> ((!rd_n || !wr_n) && !den_n)); // R5
  AST_READ_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe); // R5
  AST_WAIT_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_T2 || phase == PH_TW) && !ready) |=> (phase == PH_TW)); // R6
  AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_T2 || phase == PH_TW) && ready) |=> (phase == PH_T3)); // R6
  AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_n && wr_n && den_n && !ad_oe)); // R8
  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ale) |-> ($stable(dt_r) && $stable(io_sel))); // R3
  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R10
  AST_NO_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R10

endmodule

bind mbus_cycle_ctrl mbc_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .phase  (phase),
  .ready  (ready),
  .ale    (ale),
  .rd_n   (rd_n),
  .wr_n   (wr_n),
  .den_n  (den_n),
  .ad_oe  (ad_oe),
  .dt_r   (dt_r),
  .io_sel (io_sel),
  .busy   (busy),
  .done   (done)
);

// File: tb/mbus_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module mbus_cycle_ctrl_bench;

  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic          req_io = 1'b0;
  logic          req_word = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] ad_in = '0;
  logic          ready = 1'b1;

  logic          busy, done, ad_oe, ale, rd_n, wr_n, den_n, dt_r, io_sel, bhe_n;
  logic [DW-1:0] rdata, ad_out;
  logic [AW-DW-1:0] a_hi;
  logic [AW-1:0] lat_addr;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // reference model state: 0 idle, 1 T1, 2 T2, 3 T3, 4 T4, 5 wait
  int            m_ph = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wdata = '0;
  logic [DW-1:0] m_rdata = '0;
  logic [AW-1:0] m_lat = '0;
  bit            m_wr = 0, m_io = 0, m_word = 0;

  always #5 clk = ~clk;

  mbus_cycle_ctrl u_mbus_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r), .io_sel(io_sel),
    .bhe_n(bhe_n), .ready(ready), .lat_addr(lat_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // model step and per-cycle comparison
  always begin
    @(posedge clk);
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_rdata = '0; m_lat = '0; m_addr = '0; m_wr = 0; m_io = 0; m_word = 0;
    end else begin
      case (m_ph)
        0: if (req_valid) begin
             m_addr = req_addr; m_wdata = req_wdata; m_wr = req_write;
             m_io = req_io; m_word = req_word; m_ph = 1;
           end
        1: m_ph = 2;
        2, 5: m_ph = ready ? 3 : 5;
        3: begin if (!m_wr) m_rdata = ad_in; m_ph = 4; end
        default: m_ph = 0;
      endcase
      if (m_ph == 1) m_lat = m_addr;
    end
    #2;
    begin
      bit    act_ph;
      bit    e_oe;
      string st;
      string t1;
      act_ph = (m_ph == 2) || (m_ph == 5) || (m_ph == 3);
      e_oe   = (m_ph == 1) || (act_ph && m_wr);
      st     = (m_ph == 4) ? "R8" : (!rst_n || m_ph == 0) ? "R1" : "R5";
      t1     = (!rst_n || m_ph == 0) ? "R1" : "R3";
      chk((m_ph == 1) ? "R4" : st, {31'd0, ale}, {31'd0, m_ph == 1});
      chk(st, {31'd0, ad_oe}, {31'd0, e_oe});
      if (m_ph == 1) chk("R3", {16'd0, ad_out}, {16'd0, m_addr[DW-1:0]});
      if (act_ph && m_wr) chk("R5", {16'd0, ad_out}, {16'd0, m_wdata});
      chk(t1, {28'd0, a_hi}, (m_ph != 0) ? {28'd0, m_addr[AW-1:DW]} : 32'd0);
      chk(st, {31'd0, rd_n}, {31'd0, !(act_ph && !m_wr)});
      chk(st, {31'd0, wr_n}, {31'd0, !(act_ph && m_wr)});
      chk(st, {31'd0, den_n}, {31'd0, !act_ph});
      chk(t1, {31'd0, dt_r}, {31'd0, (m_ph != 0) && m_wr});
      chk(t1, {31'd0, io_sel}, {31'd0, (m_ph != 0) && m_io});
      chk((m_ph == 0) ? "R1" : "R9", {31'd0, bhe_n},
          {31'd0, (m_ph == 0) ? 1'b1 : !(m_word || m_addr[0])});
      chk((m_ph == 0) ? "R1" : "R2", {31'd0, busy}, {31'd0, m_ph != 0});
      chk((m_ph == 4) ? "R8" : "R2", {31'd0, done}, {31'd0, m_ph == 4});
      chk("R7", {16'd0, rdata}, {16'd0, m_rdata});
      chk("R4", {12'd0, lat_addr}, {12'd0, m_lat});
      if (!rd_n && !wr_n) chk("R11", 32'd1, 32'd0);
    end
  end

  task automatic run_cycle(input logic [AW-1:0] a, input logic [DW-1:0] wd,
                           input bit w, input bit io, input bit word,
                           input int waits, input bit poke);
    int t0;
    int n;
    @(negedge clk);
    req_addr = a; req_wdata = wd; req_write = w; req_io = io; req_word = word;
    req_valid = 1'b1;
    ready = (waits == 0);
    @(posedge clk);
    #1 t0 = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      req_valid = 1'b1; req_addr = ~a; req_write = !w; req_wdata = ~wd;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (waits > 0) begin
      repeat (waits) @(posedge clk);
      @(negedge clk);
      ready = 1'b1;
    end
    n = 0;
    do begin
      @(posedge clk);
      #3;
      n++;
    end while (!done && n < 20);
    chk((waits == 0) ? "R2" : "R6", cyc - t0, 3 + waits);
    @(posedge clk);
    #3;
    chk("R11", {31'd0, done}, 32'd0);
    if (poke) chk("R10", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    fork
      begin
        forever begin
          @(negedge clk);
          ad_in = ad_in * 16'd5 + 16'h3C1B;
        end
      end
      begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none

    repeat (4) @(negedge clk);
    // R1: reset levels while reset is held
    chk("R1", {31'd0, busy}, 32'd0);
    chk("R1", {31'd0, rd_n & wr_n & den_n}, 32'd1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", {16'd0, rdata}, 32'd0);

    run_cycle(20'hA1234, 16'h0000, 1'b0, 1'b0, 1'b1, 0, 1'b0); // R2 read, word even
    run_cycle(20'h3BEEF, 16'h5AA5, 1'b1, 1'b1, 1'b0, 0, 1'b0); // R5 write, byte odd (R9)
    run_cycle(20'h0C0DE, 16'h0000, 1'b0, 1'b0, 1'b0, 3, 1'b0); // R6 read with waits
    run_cycle(20'hF0010, 16'h1234, 1'b1, 1'b0, 1'b1, 2, 1'b0); // R6 write with waits, R7 hold
    run_cycle(20'h45670, 16'h0000, 1'b0, 1'b1, 1'b0, 1, 1'b0); // R9 byte even
    run_cycle(20'h77777, 16'h9876, 1'b0, 1'b0, 1'b1, 0, 1'b1); // R10 poke during read
    run_cycle(20'h12345, 16'hCAFE, 1'b1, 1'b1, 1'b1, 4, 1'b1); // R10 poke during write

    for (int i = 0; i < 24; i++) begin
      logic [31:0] h;
      h = 32'h9E3779B9 * (i + 7);
      run_cycle(h[AW-1:0] ^ h[31:12], h[27:12], h[3], h[9], h[17], i % 5, h[21]);
    end

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule